// File: doc/BRIEF.md
# Video Encoder Port Bridge

The bridge sits between a host's memory-mapped register bus and the data and sync pins of a video encoder. A single 8-bit control/status register selects how pixel data from a 20-bit video port reaches the encoder's 8-bit data input. The same register holds the encoder's reset line, decides who owns the shared sync lines, and reports whether a cable load is sensed on the composite output.

In direct mode, each pixel beat forwards a fixed byte slice of the video port to the encoder. In packed mode, the low 16 bits of the port carry an RGB565 word. Each word leaves as two bytes on consecutive beats, low byte first. The sync field hands horizontal and vertical sync mastership to the encoder, or releases the shared lines. When released, the bridge withdraws its output enable and drives the lines low, so board pins can float.

Top module: `vbr_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the register holds 0x00. This means `enc_rst` is 0, `vp_sync_oe` is 1, `enc_data` is 0 and `bus_rdata` is 0.
- R2: A write with `bus_wr`=1 and `bus_addr` equal to `REG_OFF` (default 0x0D8000) updates the register on that clock edge. Writes to any other address change nothing.
- R3: A read with `bus_rd`=1 at `REG_OFF` returns the status word on `bus_rdata` after the next clock edge. Bit 0 is the encoder reset, bit 2 is load detect, bit 3 is sync release and bit 4 is packed mode. Bits 1 and 5 to 31 read 0. Any cycle without a matching read leaves `bus_rdata` at 0 after the next edge.
- R4: Read bit 2 returns the level of `load_det` in the read cycle. Writing bit 2 has no effect.
- R5: `enc_rst` equals written bit 0 from the cycle after the write.
- R6: With bit 3 at 0, `vp_sync_oe` is 1 and `vp_sync[i]` follows `enc_sync[i]` (index 0 horizontal, index 1 vertical). With bit 3 at 1, `vp_sync_oe` is 0 and `vp_sync` is 0.
- R7: In direct mode (bit 4 = 0), a beat with `pix_vld`=1 puts `vp_data[9:2]` on `enc_data` after the edge. Without a beat, `enc_data` holds its value.
- R8: In packed mode (bit 4 = 1), a first beat captures `vp_data[15:0]` and outputs bits 7:0. The next beat outputs the captured bits 15:8, whatever `vp_data` carries on it. `vp_data[19:16]` is ignored.
- R9: While bit 0 is 1, `enc_data` is 0 and the byte phase returns to the first byte. Direct mode also returns the phase to the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and pixel beats |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (24) | Byte address within the window |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| load_det | input | 1 | Cable load sensed on composite output |
| pix_vld | input | 1 | Pixel beat strobe |
| vp_data | input | VP_W (20) | Video port data |
| enc_data | output | ENC_W (8) | Encoder data pins |
| enc_rst | output | 1 | Encoder reset, active high |
| enc_sync | input | SYNC_N (2) | Sync from the encoder (0 horizontal, 1 vertical) |
| vp_sync | output | SYNC_N (2) | Sync toward the video port control lines |
| vp_sync_oe | output | 1 | Drive enable for `vp_sync` |

## Verification
The bench goes after the byte ordering of packed words. It sends gaps between beats and changes `vp_data` on the second beat, so a design that re-sampled the port or swapped bytes would emit wrong pixels. It asserts the encoder reset in the middle of a word: a design that kept the phase would start the next word on its high byte. It also writes the load-detect bit and unused bits, and writes a neighbouring address, so a design that stored those bits or decoded the address loosely would read back a wrong status word.

// File: rtl/vbr_pkg.sv
// Shared types and field positions of the video encoder port bridge.
// Assumes the status word is formed with the bit positions below.
package vbr_pkg;

    localparam int unsigned BIT_RST  = 0;
    localparam int unsigned BIT_DET  = 2;
    localparam int unsigned BIT_REL  = 3;
    localparam int unsigned BIT_MODE = 4;

    typedef struct packed {
        logic packed_mode;   // 1: RGB565 unpacking, 0: direct byte slice
        logic sync_release;  // 1: sync lines released, 0: encoder is master
        logic enc_reset;     // drives the encoder reset pin
    } ctrl_t;

endpackage

// File: rtl/vbr_regfile.sv
// Control/status register of the bridge.
// Decodes one address, stores the writable fields and returns a registered
// status word one cycle after a read. Assumes a single-cycle bus strobe.
module vbr_regfile
    import vbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter logic [ADDR_W-1:0] REG_OFF = 24'h0D8000,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              load_det,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] bus_rdata
);

    logic              hit;
    logic [DATA_W-1:0] status;

    // Address decode of the single register
    assign hit = (bus_addr == REG_OFF);

    // Store the writable fields; detect and unused bits are not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (bus_wr && hit) begin
            ctrl.enc_reset    <= bus_wdata[BIT_RST];
            ctrl.sync_release <= bus_wdata[BIT_REL];
            ctrl.packed_mode  <= bus_wdata[BIT_MODE];
        end
    end

    // Assemble the status word with unused positions at zero
    always_comb begin
        status           = '0;
        status[BIT_RST]  = ctrl.enc_reset;
        status[BIT_DET]  = load_det;
        status[BIT_REL]  = ctrl.sync_release;
        status[BIT_MODE] = ctrl.packed_mode;
    end

    // Register the read result; zero when no matching read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= (bus_rd && hit) ? status : '0;
        end
    end

endmodule

// File: rtl/vbr_pixel_path.sv
// Pixel data path from the video port to the encoder data pins.
// Direct mode forwards a byte slice; packed mode splits each 2*ENC_W word
// into two beats, low byte first. Assumes VP_W >= 2*ENC_W and VP_W >= ENC_W+2.
module vbr_pixel_path
    import vbr_pkg::*;
#(
    parameter int unsigned VP_W  = 20,
    parameter int unsigned ENC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             pix_vld,
    input  logic [VP_W-1:0]  vp_data,
    output logic [ENC_W-1:0] enc_data
);

    localparam int unsigned DIR_LSB = 2;
    localparam int unsigned DIR_MSB = DIR_LSB + ENC_W - 1;
    localparam int unsigned WORD_W  = 2 * ENC_W;

    logic             second_beat;
    logic [ENC_W-1:0] held_hi;

    // Beat-by-beat byte selection, cleared by either reset
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl.enc_reset) begin
            second_beat <= 1'b0;
            held_hi     <= '0;
            enc_data    <= '0;
        end else begin
            if (!ctrl.packed_mode) begin
                second_beat <= 1'b0;
            end
            if (pix_vld) begin
                if (!ctrl.packed_mode) begin
                    enc_data <= vp_data[DIR_MSB:DIR_LSB];
                end else if (!second_beat) begin
                    held_hi     <= vp_data[WORD_W-1:ENC_W];
                    enc_data    <= vp_data[ENC_W-1:0];
                    second_beat <= 1'b1;
                end else begin
                    enc_data    <= held_hi;
                    second_beat <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/vbr_sync_ctl.sv
// Sync ownership: passes encoder sync to the port lines when the encoder is
// master, otherwise drops the drive enable and holds the lines low.
module vbr_sync_ctl
    import vbr_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  ctrl_t             ctrl,
    input  logic [SYNC_N-1:0] enc_sync,
    output logic [SYNC_N-1:0] vp_sync,
    output logic              vp_sync_oe
);

    // Drive enable follows the sync ownership field
    assign vp_sync_oe = ~ctrl.sync_release;

    // One gate per sync line
    for (genvar i = 0; i < SYNC_N; i++) begin : g_line
        assign vp_sync[i] = ctrl.sync_release ? 1'b0 : enc_sync[i];
    end

endmodule

// File: rtl/vbr_top.sv
// Video encoder port bridge top: register, pixel path and sync control.
// Assumes one clock for bus and pixel beats, and pix_vld as the beat strobe.
module vbr_top
    import vbr_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter logic [ADDR_W-1:0] REG_OFF = 24'h0D8000,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VP_W   = 20,
    parameter int unsigned ENC_W  = 8,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              load_det,
    input  logic              pix_vld,
    input  logic [VP_W-1:0]   vp_data,
    output logic [ENC_W-1:0]  enc_data,
    output logic              enc_rst,
    input  logic [SYNC_N-1:0] enc_sync,
    output logic [SYNC_N-1:0] vp_sync,
    output logic              vp_sync_oe
);

    ctrl_t ctrl;

    vbr_regfile #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF), .DATA_W(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .load_det(load_det),
        .ctrl(ctrl), .bus_rdata(bus_rdata)
    );

    vbr_pixel_path #(.VP_W(VP_W), .ENC_W(ENC_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .pix_vld(pix_vld),
        .vp_data(vp_data), .enc_data(enc_data)
    );

    vbr_sync_ctl #(.SYNC_N(SYNC_N)) u_sync (
        .ctrl(ctrl), .enc_sync(enc_sync), .vp_sync(vp_sync),
        .vp_sync_oe(vp_sync_oe)
    );

    // Encoder reset pin is the stored reset field
    assign enc_rst = ctrl.enc_reset;

endmodule

// File: rtl/vbr_checker.sv
// Port-level properties of the bridge, bound to every vbr_top instance.
module vbr_checker #(
    parameter int unsigned ADDR_W = 24,
    parameter logic [ADDR_W-1:0] REG_OFF = 24'h0D8000,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ENC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              load_det,
    input logic [ENC_W-1:0]  enc_data,
    input logic              enc_rst,
    input logic              vp_sync_oe
);

    AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_OFF) |=> (enc_rst == $past(bus_wdata[0]))); // R5
    AST_OE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_OFF) |=> (vp_sync_oe == !$past(bus_wdata[3]))); // R6
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == REG_OFF) |=> (bus_rdata == '0)); // R3
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[DATA_W-1:5] == '0) && !bus_rdata[1]); // R3
    AST_DET_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == REG_OFF) |=> (bus_rdata[2] == $past(load_det))); // R4
    AST_DATA_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        enc_rst |=> (enc_data == '0)); // R9

endmodule

bind vbr_top vbr_checker #(
    .ADDR_W(ADDR_W), .REG_OFF(REG_OFF), .DATA_W(DATA_W), .ENC_W(ENC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .load_det(load_det), .enc_data(enc_data), .enc_rst(enc_rst),
    .vp_sync_oe(vp_sync_oe)
);

// File: tb/sim_vbr_top.sv
// Bench for vbr_top: a behavioural reference is compared on every clock,
// plus directed checks of read values and packed byte order.
module sim_vbr_top;

    localparam logic [23:0] OFF = 24'h0D8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        load_det = 1'b0, pix_vld = 1'b0;
    logic [19:0] vp_data = '0;
    logic [7:0]  enc_data;
    logic        enc_rst;
    logic [1:0]  enc_sync = '0;
    logic [1:0]  vp_sync;
    logic        vp_sync_oe;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // 200 MHz clock
    always #2.5 clk = ~clk;

    vbr_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .load_det(load_det), .pix_vld(pix_vld), .vp_data(vp_data),
        .enc_data(enc_data), .enc_rst(enc_rst), .enc_sync(enc_sync),
        .vp_sync(vp_sync), .vp_sync_oe(vp_sync_oe)
    );

    // Reference state
    bit     m_rst, m_rel, m_mode, m_phase;
    int     m_hold;
    int     m_data, m_rdata;

    // Reference update at each edge from the pre-edge state
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rst = 0; m_rel = 0; m_mode = 0; m_phase = 0;
            m_hold = 0; m_data = 0; m_rdata = 0;
        end else begin
            m_rdata = (bus_rd && bus_addr == OFF)
                    ? (m_mode * 16 + m_rel * 8 + load_det * 4 + m_rst) : 0;
            if (m_rst) begin
                m_phase = 0; m_data = 0; m_hold = 0;
            end else begin
                if (!m_mode) m_phase = 0;
                if (pix_vld) begin
                    if (!m_mode) m_data = (vp_data >> 2) & 255;
                    else if (!m_phase) begin
                        m_hold = vp_data & 16'hFFFF;
                        m_data = vp_data & 255;
                        m_phase = 1;
                    end else begin
                        m_data = (m_hold >> 8) & 255;
                        m_phase = 0;
                    end
                end
            end
            if (bus_wr && bus_addr == OFF) begin
                m_rst = bus_wdata[0]; m_rel = bus_wdata[3]; m_mode = bus_wdata[4];
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7/R8/R9 enc_data", int'(enc_data), m_data);
            check("R5 enc_rst", int'(enc_rst), int'(m_rst));
            check("R6 vp_sync_oe", int'(vp_sync_oe), int'(!m_rel));
            check("R6 vp_sync", int'(vp_sync), m_rel ? 0 : int'(enc_sync));
            check("R3 bus_rdata", int'(bus_rdata), m_rdata);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd_check(input string tag, input int exp);
        bus_rd = 1; bus_addr = OFF;
        step();
        bus_rd = 0; bus_addr = '0;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic beat(input logic [19:0] d);
        pix_vld = 1; vp_data = d;
        step();
        pix_vld = 0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        // R1: reset state seen while rst_n is low
        check("R1 enc_rst in reset", int'(enc_rst), 0);
        check("R1 vp_sync_oe in reset", int'(vp_sync_oe), 1);
        check("R1 enc_data in reset", int'(enc_data), 0);
        check("R1 bus_rdata in reset", int'(bus_rdata), 0);
        rst_n = 1;
        step();
        rd_check("R1 register after reset", 0);

        // R7: direct slice with gaps between beats
        for (int i = 0; i < 12; i++) begin
            if (i % 3 == 2) step();
            else beat(20'(i * 24'h1357B + 24'h0A5A5));
        end
        beat(20'h003FC);
        check("R7 direct slice", int'(enc_data), 8'hFF);
        step();
        check("R7 held without beat", int'(enc_data), 8'hFF);

        // R4: detect bit follows the input and ignores writes
        load_det = 1;
        wr(OFF, 32'h0000_0004);
        rd_check("R4 detect high, write ignored", 32'h04);
        load_det = 0;
        rd_check("R4 detect low", 32'h00);

        // R2 / R3: all bits written, only stored fields read back
        wr(OFF, 32'hFFFF_FFFF);
        rd_check("R2 R3 write all ones", 32'h19);
        check("R5 reset asserted", int'(enc_rst), 1);
        // R9: no data while encoder reset is asserted
        beat(20'hFFFFF);
        beat(20'h12345);
        check("R9 data cleared in reset", int'(enc_data), 0);

        // R8: packed mode, sync released
        wr(OFF, 32'h18);
        beat(20'hF_A1B2);
        check("R8 low byte first", int'(enc_data), 8'hB2);
        step();
        beat(20'h0_0000);
        check("R8 high byte from held word", int'(enc_data), 8'hA1);
        for (int i = 0; i < 10; i++) begin
            enc_sync = 2'(i);
            beat(20'(i * 24'h2E1D3 + 24'h11));
        end

        // R2: neighbouring address is not decoded
        wr(OFF + 24'd4, 32'h00);
        rd_check("R2 other address ignored", 32'h18);

        // R6: encoder is sync master again
        wr(OFF, 32'h10);
        for (int i = 0; i < 4; i++) begin
            enc_sync = 2'(i);
            step();
            check("R6 sync follows encoder", int'(vp_sync), i);
        end

        // R9: reset in the middle of a word restarts the phase
        beat(20'h0_5566);
        wr(OFF, 32'h11);
        wr(OFF, 32'h10);
        beat(20'h0_7788);
        check("R9 phase restarted", int'(enc_data), 8'h88);
        beat(20'h0_0000);
        check("R9 second byte after restart", int'(enc_data), 8'h77);

        // R9: direct mode mid-word returns phase to the first byte
        beat(20'h0_ABCD);
        wr(OFF, 32'h00);
        beat(20'h0_0000);
        wr(OFF, 32'h10);
        beat(20'h0_4321);
        check("R9 phase cleared by direct mode", int'(enc_data), 8'h21);
        repeat (3) step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule